// File: doc/BRIEF.md
# Masked Byte Field Comparator

This block compares a selection of bytes taken from a 32-bit register value with a byte string held in storage, and reports the ordering as a 2-bit condition code. A 4-bit mask picks which register bytes take part. The picked bytes are squeezed together, keeping their left-to-right order, into one contiguous field. That field is then compared with the same number of consecutive storage bytes, starting at a given 24-bit address.

The storage bytes come in one at a time over a byte-wide read port with a request/valid handshake. The compare works from the leftmost byte and stops at the first byte that differs. Because of this, the block never asks for more bytes than the mask selects, and it stops fetching once the outcome is known. An all-zero mask still reads one byte, so that an access fault at the address can surface, and it always reports equality. A fault reported on the read port aborts the operation and passes through as a flag. When that happens the condition code from the previous operation is left in place.

Top module: `mask_field_cmp`

## Requirements
- R1: Mask bit 3 selects register bits 31:24 (the leftmost byte) and mask bit 0 selects bits 7:0. The selected bytes are packed leftmost-first, and unselected bytes never influence the result.
- R2: The storage bytes are read from consecutive increasing addresses, starting at `addr_i` and wrapping modulo 2^24. The k-th packed register byte is paired with the byte at `addr_i + k`.
- R3: The comparison ends at the first unequal byte. No read is requested after that byte, and none after `done_o`.
- R4: `cc_o` is 0 when all selected bytes match, 1 when the register field is lower, and 2 when it is higher. Bytes compare as unsigned numbers.
- R5: With a nonzero mask, the number of accepted reads never exceeds the number of ones in the mask.
- R6: With a zero mask, exactly one read is made, at `addr_i`, and `cc_o` is 0 whatever the data.
- R7: A response with `mem_fault_i` high ends the operation. `fault_o` and `done_o` are high together for that one cycle, `cc_o` keeps its previous value, and no further read follows.
- R8: At most one request is outstanding. `mem_req_o` stays high with a stable `mem_addr_o` until `mem_valid_i` is seen.
- R9: `done_o` is a one-cycle pulse, asserted the cycle after the deciding response is accepted. `cc_o` holds its value until the next completion.
- R10: A `start_i` pulse that arrives while an operation is running is ignored.
- R11: After reset, `mem_req_o`, `done_o` and `fault_o` are low and `cc_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| reg_i | input | 32 | Register operand |
| mask_i | input | 4 | Byte select mask, bit 3 = leftmost byte |
| addr_i | input | 24 | Storage operand start address |
| mem_req_o | output | 1 | Read request, held until a response |
| mem_addr_o | output | 24 | Read address |
| mem_valid_i | input | 1 | Read response valid |
| mem_data_i | input | 8 | Read data byte |
| mem_fault_i | input | 1 | Response carries an access fault |
| done_o | output | 1 | One-cycle completion pulse |
| cc_o | output | 2 | Condition code |
| fault_o | output | 1 | Access fault flag, pulses with done_o |

## Verification
Suppose the packed operand or the byte index goes wrong inside the block. The first read address that differs from `addr_i + k` shows it, one cycle after the response that advanced the index. A wrong count or limit shows up in the number of reads accepted before `done_o`: one read too many, or a completion one exchange early. A faulty compare or fault path appears on `cc_o` and `fault_o` in the cycle of `done_o`, which comes one clock after the deciding response.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  typedef enum logic [1:0] {
    CC_EQ   = 2'd0,
    CC_LOW  = 2'd1,
    CC_HIGH = 2'd2
  } cc_t;

  // ordering of two unsigned quantities given as less/greater flags
  function automatic cc_t cc_of(input logic lt, input logic gt);
    if (lt)      return CC_LOW;
    else if (gt) return CC_HIGH;
    else         return CC_EQ;
  endfunction
endpackage

// File: rtl/mfc_pack.sv
module mfc_pack #(
  parameter int LANES = 4,
  parameter int BW    = 8,
  localparam int RW   = LANES * BW,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic [RW-1:0]    reg_i,
  input  logic [LANES-1:0] mask_i,
  output logic [RW-1:0]    packed_o,
  output logic [CW-1:0]    count_o
);
  always_comb begin
    int k;
    packed_o = '0;
    k = 0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        packed_o[RW-1-k*BW -: BW] = reg_i[i*BW +: BW];
        k++;
      end
    end
    count_o = CW'(k);
  end
endmodule

// File: rtl/mfc_byte_cmp.sv
module mfc_byte_cmp
  import mfc_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic [BW-1:0] lhs_i,
  input  logic [BW-1:0] rhs_i,
  output cc_t           cc_o,
  output logic          neq_o
);
  assign cc_o  = cc_of(lhs_i < rhs_i, lhs_i > rhs_i);
  assign neq_o = (cc_o != CC_EQ);
endmodule

// File: rtl/mfc_ctrl.sv
module mfc_ctrl
  import mfc_pkg::*;
#(
  parameter int LANES = 4,
  parameter int BW    = 8,
  parameter int AW    = 24,
  localparam int RW   = LANES * BW,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [RW-1:0] packed_i,
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] addr_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic          mem_fault_i,
  output logic [BW-1:0] lhs_o,
  input  cc_t           cmp_cc_i,
  input  logic          cmp_neq_i,
  output logic          done_o,
  output cc_t           cc_o,
  output logic          fault_o,
  output logic          beat_o,
  output logic [CW-1:0] idx_o,
  output logic [CW-1:0] limit_o,
  output logic          zero_o
);
  logic          busy_q, zero_q, done_q, fault_q;
  logic [CW-1:0] idx_q, limit_q;
  logic [RW-1:0] opnd_q;
  logic [AW-1:0] base_q;
  cc_t           cc_q;
  logic          beat, last;

  assign beat = busy_q & mem_valid_i;
  assign last = ((idx_q + CW'(1)) == limit_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      zero_q  <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      idx_q   <= '0;
      limit_q <= '0;
      opnd_q  <= '0;
      base_q  <= '0;
      cc_q    <= CC_EQ;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (!busy_q && start_i) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        opnd_q  <= packed_i;
        base_q  <= addr_i;
        zero_q  <= (count_i == '0);
        limit_q <= (count_i == '0) ? CW'(1) : count_i;
      end else if (beat) begin
        if (mem_fault_i) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          fault_q <= 1'b1;
        end else if (zero_q || last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cc_q   <= zero_q ? CC_EQ : cmp_cc_i;
        end else if (cmp_neq_i) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cc_q   <= cmp_cc_i;
        end else begin
          idx_q  <= idx_q + CW'(1);
          opnd_q <= opnd_q << BW;
        end
      end
    end
  end

  assign mem_req_o  = busy_q;
  assign mem_addr_o = base_q + AW'(idx_q);
  assign lhs_o      = opnd_q[RW-1 -: BW];
  assign done_o     = done_q;
  assign cc_o       = cc_q;
  assign fault_o    = fault_q;
  assign beat_o     = beat;
  assign idx_o      = idx_q;
  assign limit_o    = limit_q;
  assign zero_o     = zero_q;
endmodule

// File: rtl/mask_field_cmp.sv
module mask_field_cmp
  import mfc_pkg::*;
#(
  parameter int LANES = 4,
  parameter int BW    = 8,
  parameter int AW    = 24,
  localparam int RW   = LANES * BW,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [RW-1:0]    reg_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [AW-1:0]    addr_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_valid_i,
  input  logic [BW-1:0]    mem_data_i,
  input  logic             mem_fault_i,
  output logic             done_o,
  output logic [1:0]       cc_o,
  output logic             fault_o
);
  logic [RW-1:0] packed_w;
  logic [CW-1:0] count_w;
  logic [BW-1:0] lhs_w;
  cc_t           cmp_cc_w, cc_w;
  logic          cmp_neq_w;
  // named internal events for the checker
  logic          w_beat, w_zero;
  logic [CW-1:0] w_idx, w_limit;

  mfc_pack #(.LANES(LANES), .BW(BW)) u_pack (
    .reg_i(reg_i), .mask_i(mask_i), .packed_o(packed_w), .count_o(count_w)
  );

  mfc_byte_cmp #(.BW(BW)) u_cmp (
    .lhs_i(lhs_w), .rhs_i(mem_data_i), .cc_o(cmp_cc_w), .neq_o(cmp_neq_w)
  );

  mfc_ctrl #(.LANES(LANES), .BW(BW), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .packed_i(packed_w), .count_i(count_w), .addr_i(addr_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_fault_i(mem_fault_i),
    .lhs_o(lhs_w), .cmp_cc_i(cmp_cc_w), .cmp_neq_i(cmp_neq_w),
    .done_o(done_o), .cc_o(cc_w), .fault_o(fault_o),
    .beat_o(w_beat), .idx_o(w_idx), .limit_o(w_limit), .zero_o(w_zero)
  );

  assign cc_o = cc_w;
endmodule

// File: rtl/mfc_checker.sv
module mfc_checker #(
  parameter int AW = 24,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_valid_i,
  input logic          done_o,
  input logic [1:0]    cc_o,
  input logic          fault_o,
  input logic          w_beat,
  input logic [CW-1:0] w_idx,
  input logic [CW-1:0] w_limit,
  input logic          w_zero
);
  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    w_beat |-> (w_idx < w_limit)); // R5
  AST_ZERO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    w_beat && w_zero |-> (w_idx == '0)); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_FAULT_KEEPS_CC: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> done_o && $stable(cc_o)); // R7
  AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_o); // R3
  AST_CC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cc_o != 2'd3); // R4
endmodule

bind mask_field_cmp mfc_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_valid_i(mem_valid_i), .done_o(done_o), .cc_o(cc_o), .fault_o(fault_o),
  .w_beat(w_beat), .w_idx(w_idx), .w_limit(w_limit), .w_zero(w_zero)
);

// File: tb/mask_field_cmp_bench.sv
module mask_field_cmp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] reg_v = '0;
  logic [3:0]  mask = '0;
  logic [23:0] addr = '0;
  logic        mem_req, mem_valid, mem_fault, done, fault;
  logic [23:0] mem_addr;
  logic [7:0]  mem_data;
  logic [1:0]  cc;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int beats = 0;
  bit addr_bad = 0;
  logic [31:0] stor_q = '0;
  logic [23:0] base_q = '0;
  bit          flt_en = 0;
  logic [23:0] flt_addr = '0;

  always #2 clk = ~clk;

  mask_field_cmp u_mask_field_cmp (
    .clk(clk), .rst_n(rst_n), .start_i(start), .reg_i(reg_v), .mask_i(mask),
    .addr_i(addr), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_valid_i(mem_valid), .mem_data_i(mem_data), .mem_fault_i(mem_fault),
    .done_o(done), .cc_o(cc), .fault_o(fault)
  );

  function automatic logic [7:0] byte_at(input logic [23:0] a);
    logic [23:0] off;
    off = a - base_q;
    if (off < 24'd4) return stor_q[31 - 8*off[1:0] -: 8];
    return 8'hEE;
  endfunction

  // storage model: answers each request one cycle later
  always @(posedge clk) begin
    if (mem_req && mem_valid) begin
      if (mem_addr != base_q + 24'(beats)) addr_bad = 1;
      beats = beats + 1;
    end
    mem_valid <= rst_n && mem_req && !mem_valid;
    mem_data  <= byte_at(mem_addr);
    mem_fault <= mem_req && !mem_valid && flt_en && (mem_addr == flt_addr);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] r, input logic [3:0] m,
                        input logic [23:0] a, input logic [31:0] s,
                        input bit poke, output bit got_done);
    int n;
    @(negedge clk);
    stor_q = s; base_q = a; beats = 0; addr_bad = 0;
    reg_v = r; mask = m; addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // a second start while busy, with different operands
      reg_v = ~r; mask = 4'h0; addr = a + 24'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    got_done = done;
  endtask

  // reg, mask, storage word, expected cc, expected reads
  localparam logic [72:0] VEC [8] = '{
    {32'h11223344, 4'hF, 32'h11223344, 2'd0, 3'd4},
    {32'h11223344, 4'hF, 32'h11203344, 2'd2, 3'd2},
    {32'h11223344, 4'hF, 32'h12000000, 2'd1, 3'd1},
    {32'hAABBCCDD, 4'h5, 32'hBBDD0000, 2'd0, 3'd2},
    {32'hAABBCCDD, 4'h9, 32'hAADE0000, 2'd1, 3'd2},
    {32'h00FF0000, 4'h4, 32'h7F000000, 2'd2, 3'd1},
    {32'h12345678, 4'h0, 32'h99000000, 2'd0, 3'd1},
    {32'h80000001, 4'h1, 32'h01000000, 2'd0, 3'd1}
  };

  initial begin
    bit d;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!mem_req && !done && !fault && cc == 2'd0, "R11", "reset outputs",
        {mem_req, done, fault, cc}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      run_op(VEC[i][72:41], VEC[i][40:37], 24'h000100 + 24'(i*16),
             VEC[i][36:5], 0, d);
      chk(d, "R9", $sformatf("vec%0d done", i), d, 1);
      chk(cc == VEC[i][4:3], "R4", $sformatf("vec%0d cc (R1 R3)", i),
          cc, VEC[i][4:3]);
      chk(beats == int'(VEC[i][2:0]), "R5",
          $sformatf("vec%0d reads (R3 R6)", i), beats, VEC[i][2:0]);
      chk(!addr_bad, "R2", $sformatf("vec%0d addresses", i), addr_bad, 0);
      @(negedge clk);
      chk(!done && !mem_req, "R9", "done one cycle", {done, mem_req}, 0);
      chk(cc == VEC[i][4:3], "R9", "cc held", cc, VEC[i][4:3]);
    end

    // R2 address wrap at the top of the space
    run_op(32'hCAFEF00D, 4'hF, 24'hFFFFFE, 32'hCAFEF00D, 0, d);
    chk(cc == 2'd0 && beats == 4 && !addr_bad, "R2", "wrap",
        {cc, 8'(beats), 7'(addr_bad)}, {2'd0, 8'd4, 7'd0});

    // set cc=2 then fault on the second read
    run_op(32'h00FF0000, 4'h4, 24'h000200, 32'h10000000, 0, d);
    flt_en = 1; flt_addr = 24'h000301;
    run_op(32'h11223344, 4'hF, 24'h000300, 32'h11223344, 0, d);
    chk(d && fault, "R7", "fault flag", fault, 1);
    chk(cc == 2'd2, "R7", "cc kept", cc, 2);
    chk(beats == 2, "R7", "no read after fault", beats, 2);
    // zero mask still probes one byte and sees a fault there
    flt_addr = 24'h000400;
    run_op(32'h0, 4'h0, 24'h000400, 32'h0, 0, d);
    chk(fault && beats == 1, "R6", "zero mask fault probe",
        {fault, 8'(beats)}, {1'b1, 8'd1});
    flt_en = 0;
    run_op(32'h11223344, 4'hF, 24'h000500, 32'h11223344, 0, d);
    chk(!fault && cc == 2'd0, "R7", "clean after fault", {fault, cc}, 0);

    // R10 start pulse while busy is ignored
    run_op(32'h01020304, 4'hF, 24'h000600, 32'h01020305, 1, d);
    chk(cc == 2'd1 && beats == 4 && !addr_bad, "R10", "busy start ignored",
        {cc, 8'(beats)}, {2'd1, 8'd4});
    repeat (4) @(negedge clk);
    chk(!mem_req && !done, "R10", "no extra op", {mem_req, done}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule